// File: doc/BRIEF.md
# Interrupt Source Pending/Queued State Array

This block keeps a two-bit state, P (pending) and Q (queued), for each of a parameterised number of interrupt sources. P is bit 1 and Q is bit 0 of every value written as `PQ`. The state decides whether a trigger pulse on a source is turned into a notification for a downstream routing stage. Triggers that arrive while a notification is already outstanding are folded into the Q bit instead of being forwarded. Software later collects them with an end-of-interrupt (EOI) load.

Software reaches the state through a load-only management port. The address is `{source, op[2:0]}`, and each load returns a small result one cycle later. Notifications leave on a valid/ready handshake that carries the source number. Each source holds at most one notification while the output is stalled, and the lowest-numbered source wins arbitration. All state is held in on-chip flops.

Top module: `pq_source_array`

## Requirements
- R1: After reset every source holds PQ=01 (off), `notifyValid` is 0 and `mmioRvalid` is 0.
- R2: A trigger on a source in PQ=00 moves it to PQ=10 and produces exactly one notification carrying that source number.
- R3: A trigger on a source in PQ=10 moves it to PQ=11 and produces no notification. A trigger in PQ=11 leaves PQ=11 and produces no notification.
- R4: A trigger on a source in PQ=01 has no effect: the state stays 01 and no notification is produced.
- R5: An EOI load (op 0) returns the old Q in bit 0, with all other data bits 0, and clears P. If the old Q was 1 it also clears Q and produces one notification for that source.
- R6: A load with op 4, 5, 6 or 7 sets PQ to op[1:0] (00, 01, 10, 11) and returns the previous PQ in data bits [1:0], with P in bit 1.
- R7: A load with op 1 returns the current PQ without changing it. Ops 2 and 3 return 0 and change nothing.
- R8: `mmioRvalid` is high exactly in the cycle after a cycle with `mmioRd` high, and `mmioRdata` holds that load's result in that cycle.
- R9: `notifyValid` stays high until it is accepted with `notifyReady`. Each source holds at most one pending notification. The offered source is the lowest-numbered pending one.
- R10: When a load and a trigger hit the same source in the same cycle, the load acts first and the trigger is then applied to the resulting state. The load returns the state from before both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trig | input | NUM_SRC | Per-source trigger pulses |
| mmioRd | input | 1 | Load request strobe |
| mmioAddr | input | SRC_W+3 | Load address: {source, op} |
| mmioRvalid | output | 1 | Load result valid |
| mmioRdata | output | DATA_W | Load result |
| notifyValid | output | 1 | Notification offered |
| notifyReady | input | 1 | Downstream accepts notification |
| notifySrc | output | SRC_W | Source number of the offered notification |

## Verification
The bench targets several corner cases. One is coalescing in PQ=10 and 11: a design that forwards there would emit repeated notifications. Another is an EOI with Q set, which must re-notify; a wrong design would lose events or leave Q stuck. Triggers on an off source must not wake it. A load and a trigger on the same source in one cycle must apply in the fixed order; a design that got it backwards would land in the wrong state or drop the notification. A stalled output with several sources pending must grant the lowest-numbered source, and must never present more than one notification per source. Getting that wrong would reorder or duplicate events.

// File: rtl/pq_pkg.sv
package pq_pkg;
  typedef struct packed {
    logic       eoi;
    logic       setEn;
    logic [1:0] setVal;
  } pqStrb_t;

  localparam logic [1:0] PQ_OFF = 2'b01;
endpackage

// File: rtl/pq_ctrl.sv
module pq_ctrl
  import pq_pkg::*;
#(
  parameter int SRC_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                mmioRd,
  input  logic [SRC_W+2:0]    mmioAddr,
  input  logic [1:0]          oldPq,
  output pqStrb_t             strb,
  output logic [SRC_W-1:0]    mmioSrc,
  output logic                mmioRvalid,
  output logic [DATA_W-1:0]   mmioRdata
);
  logic [2:0]        op;
  logic [DATA_W-1:0] rspNext;

  assign op      = mmioAddr[2:0];
  assign mmioSrc = mmioAddr[SRC_W+2:3];

  always_comb begin
    strb        = '0;
    strb.eoi    = mmioRd && (op == 3'd0);
    strb.setEn  = mmioRd && op[2];
    strb.setVal = op[1:0];
  end

  always_comb begin
    rspNext = '0;
    case (op)
      3'd0:    rspNext[0]   = oldPq[0];
      3'd2,
      3'd3:    rspNext      = '0;
      default: rspNext[1:0] = oldPq;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mmioRvalid <= 1'b0;
      mmioRdata  <= '0;
    end else begin
      mmioRvalid <= mmioRd;
      if (mmioRd) mmioRdata <= rspNext;
    end
  end

  // R8
  rvalid_after_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    mmioRd |=> mmioRvalid);
  // R8
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !mmioRd |=> !mmioRvalid);
endmodule

// File: rtl/pq_datapath.sv
module pq_datapath
  import pq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int SRC_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] trig,
  input  pqStrb_t            strb,
  input  logic [SRC_W-1:0]   mmioSrc,
  input  logic               notifyReady,
  output logic [1:0]         oldPq,
  output logic               notifyValid,
  output logic [SRC_W-1:0]   notifySrc
);
  logic [1:0]         pqState [NUM_SRC];
  logic [1:0]         pqNext  [NUM_SRC];
  logic [NUM_SRC-1:0] pendQ, pendSet, grant;

  assign oldPq = pqState[mmioSrc];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic       sel;
    logic [1:0] afterLoad;
    logic       emitLoad, emitTrig;

    assign sel = (mmioSrc == SRC_W'(i));

    always_comb begin
      afterLoad = pqState[i];
      emitLoad  = 1'b0;
      if (sel && strb.eoi) begin
        afterLoad[1] = 1'b0;
        if (pqState[i][0]) begin
          afterLoad[0] = 1'b0;
          emitLoad     = 1'b1;
        end
      end else if (sel && strb.setEn) begin
        afterLoad = strb.setVal;
      end
    end

    always_comb begin
      pqNext[i] = afterLoad;
      emitTrig  = 1'b0;
      if (trig[i]) begin
        case (afterLoad)
          2'b00:   begin pqNext[i] = 2'b10; emitTrig = 1'b1; end
          2'b10:   pqNext[i] = 2'b11;
          default: pqNext[i] = afterLoad;
        endcase
      end
    end

    assign pendSet[i] = emitLoad | emitTrig;

    always_ff @(posedge clk) begin
      if (!rstN) pqState[i] <= PQ_OFF;
      else       pqState[i] <= pqNext[i];
    end

    // R4
    off_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pqState[i] == 2'b01 && !(sel && (strb.eoi || strb.setEn))) |=> pqState[i] == 2'b01);
    // R3
    full_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pqState[i] == 2'b11 && !(sel && (strb.eoi || strb.setEn))) |=> pqState[i] == 2'b11);
  end

  always_comb begin
    grant     = '0;
    notifySrc = '0;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (pendQ[k]) begin
        grant     = '0;
        grant[k]  = 1'b1;
        notifySrc = SRC_W'(k);
      end
    end
  end

  assign notifyValid = |pendQ;

  always_ff @(posedge clk) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= (pendQ & ~(grant & {NUM_SRC{notifyReady}})) | pendSet;
  end

  // R9
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));
  // R9
  hold_until_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    (notifyValid && !notifyReady) |=> notifyValid);
endmodule

// File: rtl/pq_source_array.sv
module pq_source_array
  import pq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int DATA_W  = 8,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] trig,
  input  logic               mmioRd,
  input  logic [SRC_W+2:0]   mmioAddr,
  output logic               mmioRvalid,
  output logic [DATA_W-1:0]  mmioRdata,
  output logic               notifyValid,
  input  logic               notifyReady,
  output logic [SRC_W-1:0]   notifySrc
);
  pqStrb_t          strb;
  logic [SRC_W-1:0] mmioSrc;
  logic [1:0]       oldPq;

  pq_ctrl #(.SRC_W(SRC_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .mmioRd(mmioRd), .mmioAddr(mmioAddr),
    .oldPq(oldPq), .strb(strb), .mmioSrc(mmioSrc),
    .mmioRvalid(mmioRvalid), .mmioRdata(mmioRdata)
  );

  pq_datapath #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_dp (
    .clk(clk), .rstN(rstN), .trig(trig), .strb(strb), .mmioSrc(mmioSrc),
    .notifyReady(notifyReady), .oldPq(oldPq),
    .notifyValid(notifyValid), .notifySrc(notifySrc)
  );
endmodule

// File: tb/pq_source_array_tb.sv
`timescale 1ns/1ps
module pq_source_array_tb;
  localparam int N = 8;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  trig = '0;
  logic          mmioRd = 1'b0;
  logic [SW+2:0] mmioAddr = '0;
  logic          mmioRvalid, notifyValid;
  logic [7:0]    mmioRdata;
  logic          notifyReady = 1'b0;
  logic [SW-1:0] notifySrc;

  int errors = 0, checks = 0, cycles = 0;
  int mPq [N];
  bit mPend [N];
  bit eRv;
  int eRd;

  always #2.5 clk = ~clk;
  always @(posedge clk) cycles++;

  pq_source_array u_dut (
    .clk(clk), .rstN(rstN), .trig(trig), .mmioRd(mmioRd), .mmioAddr(mmioAddr),
    .mmioRvalid(mmioRvalid), .mmioRdata(mmioRdata), .notifyValid(notifyValid),
    .notifyReady(notifyReady), .notifySrc(notifySrc)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int lowestPend();
    for (int k = 0; k < N; k++) if (mPend[k]) return k;
    return -1;
  endfunction

  task automatic compareAll(string tag);
    int lp = lowestPend();
    chk(tag, "notifyValid", int'(notifyValid), int'(lp >= 0));
    if (lp >= 0) chk(tag, "notifySrc", int'(notifySrc), lp);
    chk(tag, "mmioRvalid", int'(mmioRvalid), int'(eRv));
    if (eRv) chk(tag, "mmioRdata", int'(mmioRdata), eRd);
  endtask

  task automatic step(string tag, logic [N-1:0] t, bit rd, int src, int op, bit rdy);
    int lp;
    @(negedge clk);
    trig = t; mmioRd = rd; mmioAddr = (SW+3)'((src << 3) | op); notifyReady = rdy;
    lp = lowestPend();
    if (rdy && lp >= 0) mPend[lp] = 0;
    eRv = rd;
    if (rd) begin
      int old = mPq[src];
      if (op == 0) begin
        eRd = old & 1;
        if (old & 1) begin mPq[src] = 0; mPend[src] = 1; end
        else mPq[src] = old & 1;
      end else if (op >= 4) begin
        eRd = old; mPq[src] = op & 3;
      end else if (op == 1) eRd = old;
      else eRd = 0;
    end
    for (int k = 0; k < N; k++) if (t[k]) begin
      if (mPq[k] == 0) begin mPq[k] = 2; mPend[k] = 1; end
      else if (mPq[k] == 2) mPq[k] = 3;
    end
    @(posedge clk); #1;
    compareAll(tag);
  endtask

  initial begin
    wait (cycles > 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++) begin mPq[k] = 1; mPend[k] = 0; end
    eRv = 0; eRd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    compareAll("R1");
    step("R1", '0, 1, 0, 1, 0);
    step("R1", '0, 1, 7, 1, 0);
    // enable source 3, then trigger repeatedly with output stalled
    step("R6", '0, 1, 3, 4, 0);
    step("R2", 8'h08, 0, 0, 0, 0);
    step("R3", 8'h08, 0, 0, 0, 0);
    step("R3", 8'h08, 0, 0, 0, 0);
    step("R3", '0, 1, 3, 1, 0);
    step("R9", '0, 0, 0, 0, 0);
    // off source ignores triggers
    step("R4", 8'h20, 0, 0, 0, 0);
    step("R4", '0, 1, 5, 1, 0);
    // several pending, lowest first
    step("R6", '0, 1, 1, 4, 0);
    step("R6", '0, 1, 6, 4, 0);
    step("R9", 8'h42, 0, 0, 0, 0);
    step("R9", '0, 0, 0, 0, 1);
    step("R9", '0, 0, 0, 0, 1);
    step("R9", '0, 0, 0, 0, 1);
    step("R9", '0, 0, 0, 0, 1);
    // EOI with Q set re-notifies, then EOI with Q clear
    step("R5", '0, 1, 3, 0, 0);
    step("R5", '0, 1, 3, 0, 1);
    step("R5", '0, 1, 3, 1, 1);
    step("R6", '0, 1, 3, 7, 1);
    step("R6", '0, 1, 3, 6, 1);
    step("R6", '0, 1, 3, 5, 1);
    step("R7", '0, 1, 3, 2, 1);
    step("R7", '0, 1, 3, 3, 1);
    step("R7", '0, 1, 3, 1, 1);
    step("R8", '0, 1, 4, 1, 1);
    step("R8", '0, 0, 0, 0, 1);
    // load and trigger on the same source in one cycle
    step("R10", 8'h04, 1, 2, 4, 0);
    step("R10", '0, 1, 2, 1, 1);
    step("R10", 8'h04, 1, 2, 0, 1);
    step("R10", '0, 1, 2, 1, 1);
    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom_range(0, 9));
      step("R2", N'($urandom) & N'($urandom), r < 6, int'($urandom_range(0, N-1)),
           int'($urandom_range(0, 7)), $urandom_range(0, 2) != 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule